// File: doc/BRIEF.md
# Checkerboard Self-Test Wrapper for a Single-Port SRAM

This block sits between a single-port, word-oriented synchronous SRAM and the logic that normally uses it. A test-enable input chooses who drives the memory. When it is low, the functional address, write data, write strobe and read strobe pass straight to the memory. When it is high, a built-in sequencer takes over those lines and runs a checkerboard march over the whole address space.

The first pass after enable writes the alternating-bit word 0x2AA (bit 0 clear, bits alternate upward) into every address in ascending order. Each later pass visits every address in ascending order. For each address it spends one cycle reading and one cycle writing back the complement of the value it expects to find. The read word is compared on the write cycle, which matches a one-cycle read latency. The expected word therefore alternates between 0x2AA and 0x155 from pass to pass. The march wraps around without stopping for as long as enable stays high. Each mismatching address raises the error output for one cycle, so the block serves both production pass/fail screening and counting upsets under irradiation.

Top module: `sram_chk_wrap`

## Requirements
- R1: While `test_en_i` is low, the memory-side address, write data, write strobe and read strobe equal the functional inputs. `func_rdata_o` always equals `mem_rdata_i`.
- R2: After `test_en_i` is first sampled high, the next 2^ADDR_W cycles each write 0x2AA, with no read, to addresses 0, 1, ..., 2^ADDR_W-1 in turn.
- R3: In every later pass, each address takes a read cycle (read strobe high, write strobe low) followed by a write cycle to the same address. Addresses ascend from 0, and read and write are never high together.
- R4: The write cycle in check pass p stores the complement of that pass's expected word. The expected word is 0x2AA for odd p (p=1 is the first check pass) and 0x155 for even p.
- R5: A mismatch between the read word and the expected word raises `err_o` for exactly one cycle. That cycle is the one right after the write cycle of that address.
- R6: One address with several wrong bits gives a single one-cycle pulse. An address that reads back correctly gives no pulse.
- R7: With `test_en_i` held high, the address counter wraps from 2^ADDR_W-1 to 0 and the check passes repeat without end.
- R8: Dropping `test_en_i` returns the sequencer to idle and clears `err_o` on the next cycle. The next enable restarts with the writing pass at address 0.
- R9: During and after reset, `err_o` is low and the tester drives no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en_i | input | 1 | Selects the tester and keeps the march running |
| func_addr_i | input | ADDR_W | Functional address |
| func_wdata_i | input | DATA_W | Functional write data |
| func_we_i | input | 1 | Functional write strobe |
| func_re_i | input | 1 | Functional read strobe |
| func_rdata_o | output | DATA_W | Read data back to the functional path |
| mem_addr_o | output | ADDR_W | Address to the SRAM |
| mem_wdata_o | output | DATA_W | Write data to the SRAM |
| mem_we_o | output | 1 | Write strobe to the SRAM |
| mem_re_o | output | 1 | Read strobe to the SRAM |
| mem_rdata_i | input | DATA_W | Registered read data from the SRAM |
| err_o | output | 1 | One-cycle pulse per failing address |

## Verification
The bench builds the wrapper with ADDR_W=3, which gives an eight-word memory, and keeps DATA_W=10. At this size four full check passes take under eighty cycles. That makes it practical to predict every memory-side port value and every `err_o` cycle across the whole march. A stuck-bit fault model in the behavioural SRAM is swept over every address: a single stuck-high bit, a whole word stuck low, two adjacent faulty addresses, and a fault in every word. This makes the pulse timing, the per-pass alternation of the pattern and the wrap-around exhaustive for this depth.

// File: rtl/sram_chk_pkg.sv
package sram_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } tst_state_e;

    // Alternating-bit word: odd bit positions set, even positions clear.
    function automatic logic [63:0] checker_word(input int unsigned width);
        logic [63:0] w;
        w = '0;
        for (int unsigned i = 0; i < 64; i++) begin
            if ((i % 2 == 1) && (i < width)) begin
                w[i] = 1'b1;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/sram_chk_seq.sv
module sram_chk_seq
    import sram_chk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    output logic [ADDR_W-1:0] t_addr_o,
    output logic [DATA_W-1:0] t_wdata_o,
    output logic              t_we_o,
    output logic              t_re_o,
    output logic              cmp_en_o,
    output logic [DATA_W-1:0] exp_o
);
    localparam logic [DATA_W-1:0] PAT     = DATA_W'(checker_word(DATA_W));
    localparam logic [ADDR_W-1:0] LAST_AD = {ADDR_W{1'b1}};

    typedef struct packed {
        tst_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              inv;
    } seq_t;

    seq_t s_d, s_q;
    logic [DATA_W-1:0] exp_w;

    always_comb begin
        s_d       = s_q;
        exp_w     = s_q.inv ? ~PAT : PAT;
        t_addr_o  = s_q.addr;
        t_wdata_o = '0;
        t_we_o    = 1'b0;
        t_re_o    = 1'b0;
        cmp_en_o  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (en_i) begin
                    s_d.st   = ST_FILL;
                    s_d.addr = '0;
                    s_d.inv  = 1'b0;
                end
            end
            ST_FILL: begin
                t_we_o    = 1'b1;
                t_wdata_o = PAT;
                if (!en_i) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.addr == LAST_AD) begin
                    s_d.st   = ST_READ;
                    s_d.addr = '0;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end
            ST_READ: begin
                t_re_o = 1'b1;
                s_d.st = en_i ? ST_WRITE : ST_IDLE;
            end
            ST_WRITE: begin
                t_we_o    = 1'b1;
                t_wdata_o = ~exp_w;
                cmp_en_o  = 1'b1;
                if (!en_i) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.st   = ST_READ;
                    s_d.addr = s_q.addr + 1'b1;
                    if (s_q.addr == LAST_AD) begin
                        s_d.inv = ~s_q.inv;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        exp_o = exp_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, inv: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sram_chk_cmp.sv
module sram_chk_cmp #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cmp_en_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              err_o
);
    typedef struct packed {
        logic err;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        c_d.err = en_i && cmp_en_i && (rdata_i != exp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{err: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign err_o = c_q.err;

endmodule

// File: rtl/sram_chk_mux.sv
module sram_chk_mux #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 10
) (
    input  logic              sel_test_i,
    input  logic [ADDR_W-1:0] f_addr_i,
    input  logic [DATA_W-1:0] f_wdata_i,
    input  logic              f_we_i,
    input  logic              f_re_i,
    input  logic [ADDR_W-1:0] t_addr_i,
    input  logic [DATA_W-1:0] t_wdata_i,
    input  logic              t_we_i,
    input  logic              t_re_i,
    output logic [ADDR_W-1:0] m_addr_o,
    output logic [DATA_W-1:0] m_wdata_o,
    output logic              m_we_o,
    output logic              m_re_o
);
    always_comb begin
        if (sel_test_i) begin
            m_addr_o  = t_addr_i;
            m_wdata_o = t_wdata_i;
            m_we_o    = t_we_i;
            m_re_o    = t_re_i;
        end else begin
            m_addr_o  = f_addr_i;
            m_wdata_o = f_wdata_i;
            m_we_o    = f_we_i;
            m_re_o    = f_re_i;
        end
    end

endmodule

// File: rtl/sram_chk_wrap.sv
module sram_chk_wrap #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en_i,
    input  logic [ADDR_W-1:0] func_addr_i,
    input  logic [DATA_W-1:0] func_wdata_i,
    input  logic              func_we_i,
    input  logic              func_re_i,
    output logic [DATA_W-1:0] func_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              err_o
);
    logic [ADDR_W-1:0] t_addr;
    logic [DATA_W-1:0] t_wdata;
    logic [DATA_W-1:0] t_exp;
    logic              t_we;
    logic              t_re;
    logic              t_cmp;

    sram_chk_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (test_en_i),
        .t_addr_o (t_addr),
        .t_wdata_o(t_wdata),
        .t_we_o   (t_we),
        .t_re_o   (t_re),
        .cmp_en_o (t_cmp),
        .exp_o    (t_exp)
    );

    sram_chk_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (test_en_i),
        .cmp_en_i(t_cmp),
        .exp_i   (t_exp),
        .rdata_i (mem_rdata_i),
        .err_o   (err_o)
    );

    sram_chk_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sel_test_i(test_en_i),
        .f_addr_i  (func_addr_i),
        .f_wdata_i (func_wdata_i),
        .f_we_i    (func_we_i),
        .f_re_i    (func_re_i),
        .t_addr_i  (t_addr),
        .t_wdata_i (t_wdata),
        .t_we_i    (t_we),
        .t_re_i    (t_re),
        .m_addr_o  (mem_addr_o),
        .m_wdata_o (mem_wdata_o),
        .m_we_o    (mem_we_o),
        .m_re_o    (mem_re_o)
    );

    assign func_rdata_o = mem_rdata_i;

endmodule

// File: rtl/sram_chk_wrap_sva.sv
module sram_chk_wrap_sva
    import sram_chk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_en_i,
    input logic              func_we_i,
    input logic              func_re_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              err_o
);
    localparam logic [DATA_W-1:0] PAT = DATA_W'(checker_word(DATA_W));

    p_func_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en_i |-> (mem_we_o == func_we_i) && (mem_re_o == func_re_i));

    p_fill_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        test_en_i && $past(test_en_i) && !$past(test_en_i, 2)
        |-> mem_we_o && (mem_addr_o == '0) && (mem_wdata_o == PAT));

    p_no_rw_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        test_en_i |-> !(mem_we_o && mem_re_o));

    p_write_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        test_en_i && $past(test_en_i) && $past(mem_re_o)
        |-> mem_we_o && (mem_addr_o == $past(mem_addr_o)));

    p_wdata_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
        test_en_i && mem_we_o |-> (mem_wdata_o == PAT) || (mem_wdata_o == ~PAT));

    p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    p_err_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(test_en_i) && $past(mem_we_o) && $past(mem_re_o, 2));

endmodule

bind sram_chk_wrap sram_chk_wrap_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en_i  (test_en_i),
    .func_we_i  (func_we_i),
    .func_re_i  (func_re_i),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .err_o      (err_o)
);

// File: tb/sram_chk_wrap_tb_top.sv
`timescale 1ns/1ps
module sram_chk_wrap_tb_top;
    localparam int AW     = 3;
    localparam int DW     = 10;
    localparam int N      = 1 << AW;
    localparam int PASSES = 4;
    localparam logic [DW-1:0] PA = 10'h2AA;
    localparam logic [DW-1:0] PB = 10'h155;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic [AW-1:0] func_addr = '0;
    logic [DW-1:0] func_wdata = '0;
    logic          func_we = 1'b0;
    logic          func_re = 1'b0;
    logic [DW-1:0] func_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_rdata = '0;
    logic          err;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sram_chk_wrap #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en_i   (test_en),
        .func_addr_i (func_addr),
        .func_wdata_i(func_wdata),
        .func_we_i   (func_we),
        .func_re_i   (func_re),
        .func_rdata_o(func_rdata),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .mem_rdata_i (mem_rdata),
        .err_o       (err)
    );

    // Behavioural SRAM with per-address stuck-high / stuck-low bit masks.
    logic [DW-1:0] mem [N];
    logic [DW-1:0] s1  [N];
    logic [DW-1:0] s0  [N];

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= (mem_wdata | s1[mem_addr]) & ~s0[mem_addr];
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_errors = n_errors + 1;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat_of(input int p);
        return (p % 2 == 1) ? PA : PB;
    endfunction

    function automatic bit bad(input int a, input int p);
        logic [DW-1:0] e;
        e = pat_of(p);
        return ((e | s1[a]) & ~s0[a]) != e;
    endfunction

    // Enables the tester at a negedge and checks every cycle for `ncyc` cycles.
    task automatic run_march(input int ncyc, input string tag);
        test_en = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            bit exp_we, exp_re, exp_err;
            int exp_a;
            logic [DW-1:0] exp_wd;
            @(negedge clk);
            exp_wd = '0;
            if (c < N) begin
                exp_we = 1; exp_re = 0; exp_a = c; exp_wd = PA;
            end else begin
                int d, p, r;
                d = c - N; p = d / (2 * N) + 1; r = d % (2 * N);
                exp_a = r / 2;
                exp_re = (r % 2 == 0);
                exp_we = !exp_re;
                if (exp_we) exp_wd = ~pat_of(p);
            end
            exp_err = 0;
            if (c >= N + 2 && ((c - N - 2) % 2 == 0)) begin
                int d2;
                d2 = c - N - 2;
                exp_err = bad((d2 % (2 * N)) / 2, d2 / (2 * N) + 1);
            end
            chk(mem_we == exp_we, (c < N) ? "R2" : "R3", {tag, " we"}, int'(mem_we), int'(exp_we));
            chk(mem_re == exp_re, "R3", {tag, " re"}, int'(mem_re), int'(exp_re));
            chk(mem_addr == AW'(exp_a), (c >= 3 * N) ? "R7" : "R3", {tag, " addr"},
                int'(mem_addr), exp_a);
            if (exp_we)
                chk(mem_wdata == exp_wd, (c < N) ? "R2" : "R4", {tag, " wdata"},
                    int'(mem_wdata), int'(exp_wd));
            chk(err == exp_err, exp_err ? "R5" : "R6", {tag, " err"}, int'(err), int'(exp_err));
        end
    endtask

    task automatic clear_faults();
        for (int a = 0; a < N; a++) begin
            s1[a] = '0;
            s0[a] = '0;
        end
    endtask

    initial begin
        clear_faults();
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(err == 1'b0, "R9", "err in reset", int'(err), 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R9", "no access in reset",
            int'({mem_we, mem_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(err == 1'b0 && mem_we == 1'b0, "R9", "idle after reset", int'({err, mem_we}), 0);

        // R1: functional path write then read back
        func_addr = 3'd5; func_wdata = 10'h123; func_we = 1'b1;
        #1;
        chk(mem_we && mem_addr == 3'd5 && mem_wdata == 10'h123, "R1", "func write routed",
            int'(mem_wdata), 'h123);
        @(negedge clk);
        func_we = 1'b0; func_re = 1'b1;
        @(negedge clk);
        func_re = 1'b0;
        chk(func_rdata == 10'h123, "R1", "func readback", int'(func_rdata), 'h123);

        // Functional inputs held busy during test to show they are ignored.
        func_addr = 3'd7; func_wdata = '0; func_we = 1'b1;

        // Sweep fault kinds over every address.
        for (int kind = 0; kind < 5; kind++) begin
            for (int f = 0; f < N; f++) begin
                test_en = 1'b0;
                @(negedge clk);
                clear_faults();
                case (kind)
                    1: s1[f] = 10'h001;
                    2: s0[f] = 10'h3FF;
                    3: begin s1[f] = 10'h004; s0[(f + 1) % N] = 10'h200; end
                    4: for (int a = 0; a < N; a++) s1[a] = 10'h155;
                    default: ;
                endcase
                run_march(N + 2 * N * PASSES + 1, $sformatf("k%0d f%0d", kind, f));
            end
        end

        // R8: drop enable mid-march, then restart from the fill pass.
        test_en = 1'b0;
        @(negedge clk);
        clear_faults();
        s0[2] = 10'h3FF;
        run_march(N + 6, "r8_pre");
        test_en = 1'b0;
        @(negedge clk);
        chk(err == 1'b0, "R8", "err cleared on drop", int'(err), 0);
        chk(mem_we == func_we && mem_addr == func_addr, "R8", "func path after drop",
            int'(mem_addr), int'(func_addr));
        @(negedge clk);
        run_march(N + 2 * N * 2 + 1, "r8_restart");

        test_en = 1'b0;
        func_we = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule